// File: doc/BRIEF.md
# Double-Buffered Serial Routing-Matrix Configuration Port

This block is the digital control side of a 32-source by 16-destination routing matrix. A host shifts a 193-bit configuration word in over a three-wire serial link made up of a serial clock, a data line and an active-low select. The bits land in a first-rank shift register. A separate active-low update strobe copies that register into a second rank of holding registers. The second rank drives, for every destination, a 5-bit source index and an enable bit, and it also drives one global clamp-enable bit. Because the second rank only changes when the update strobe is low, a whole new routing can be loaded in the background and then applied to all outputs at once.

The block runs from a fast system clock. All four serial-side inputs pass through two-flop synchronizers, and the serial clock is sampled on its rising edge relative to the system clock. A serial data output carries the oldest bit in the shift register, so several ports can be chained with a combined word of 193 bits per device. An asynchronous active-low reset clears both ranks, which disables every output. If any of the 96 mandatory padding bits is latched as nonzero, a test-mode flag is raised.

Top module: `xpt_cfg_port`

## Requirements
- R1: While `ser_cs_n` is low, each rising edge of `ser_clk` shifts `ser_din` into the first-rank register.
- R2: While `ser_cs_n` is high, serial clock edges and update strobes change neither the first-rank register nor the second rank or its outputs.
- R3: A word is 193 bits, shifted in this order: the clamp bit, then one 6-bit field per destination from 15 down to 0, then 96 padding bits. Each field is the enable bit followed by the source index, most significant bit first.
- R4: While `upd_n` and `ser_cs_n` are both low, the second rank follows the first-rank register, so the outputs track every shift.
- R5: While `upd_n` is high, the second rank and all its outputs hold their values.
- R6: When a destination's latched enable bit is 0, its `out_sel` field reads 0 regardless of the latched index, and its `out_en` bit is 0.
- R7: After the Nth shifting edge, `ser_dout` equals the bit shifted on edge N-192. The first bit of a word therefore appears once the whole 193-bit word has been shifted in.
- R8: When `rst_n` goes low, both ranks clear to zero at once, without waiting for a clock. All `out_en` bits, `clamp_en`, `test_mode_flag` and `ser_dout` go to 0.
- R9: `clamp_en` equals the latched clamp bit.
- R10: `test_mode_flag` is 1 exactly when any latched padding bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_din | input | 1 | Serial data in |
| ser_cs_n | input | 1 | Active-low select for the serial link |
| upd_n | input | 1 | Active-low update strobe (second rank transparent while low) |
| ser_dout | output | 1 | Serial data out, used for chaining |
| out_en | output | 16 | Per-destination enable |
| out_sel | output | 80 | Per-destination 5-bit source index; destination k uses bits [5k+4:5k] |
| clamp_en | output | 1 | Global clamp enable |
| test_mode_flag | output | 1 | Set when any latched padding bit is nonzero |

## Verification
The assertions assume that every level of `ser_clk` lasts several system clocks. They also assume that `ser_din` and `ser_cs_n` settle no later than the serial edge that samples them, so that their synchronized copies line up with the detected edge. In the same way, update strobes must stay low long enough for the second rank to capture. The stimulus holds each serial clock level for six system cycles and changes data only together with the falling serial edge. It keeps the update strobe low for eight cycles, and it waits for the synchronizer latency before any output is sampled.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  // Synchronized view of the serial-side pins
  typedef struct packed {
    logic sclk;
    logic sdin;
    logic cs_n;
    logic upd_n;
  } ser_pins_t;

  // Idle levels the synchronizers take during reset
  localparam ser_pins_t SER_IDLE = '{sclk: 1'b0, sdin: 1'b0, cs_n: 1'b1, upd_n: 1'b1};

  // Lowest bit of destination k's field inside the frame register
  function automatic int field_lsb(input int pad_w, input int field_w, input int k);
    return pad_w + field_w * k;
  endfunction
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xpt_cfg_shift.sv
module xpt_cfg_shift #(
  parameter int FRAME = 193
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdin_s,
  input  logic             cs_n_s,
  output logic [FRAME-1:0] sr,
  output logic             sdout
);
  logic sclk_d;
  logic shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign shift_en = sclk_s & ~sclk_d & ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {sr[FRAME-2:0], sdin_s};
  end

  assign sdout = sr[FRAME-1];

  AST_DESELECT_HOLDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(sr)); // R2

  AST_DOUT_MOVES_ON_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_s && !sclk_d && !cs_n_s) |=> $stable(sdout)); // R7
endmodule

// File: rtl/xpt_cfg_latch.sv
module xpt_cfg_latch #(
  parameter int FRAME = 193
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FRAME-1:0] sr,
  input  logic             upd_n_s,
  input  logic             cs_n_s,
  output logic [FRAME-1:0] lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lat <= '0;
    else if (!upd_n_s && !cs_n_s) lat <= sr;
  end

  AST_UPDATE_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_n_s |=> $stable(lat)); // R5

  AST_DESELECT_HOLDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(lat)); // R2
endmodule

// File: rtl/xpt_cfg_decode.sv
module xpt_cfg_decode
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = 16,
  parameter int SEL_W = 5,
  parameter int PAD_W = 96,
  localparam int FIELD_W = SEL_W + 1,
  localparam int FRAME = 1 + N_OUT * FIELD_W + PAD_W
) (
  input  logic [FRAME-1:0]         lat,
  output logic [N_OUT-1:0]         out_en,
  output logic [N_OUT*SEL_W-1:0]   out_sel,
  output logic                     clamp_en,
  output logic                     test_mode_flag
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_dest
    localparam int LSB = field_lsb(PAD_W, FIELD_W, k);
    logic en_k;
    assign en_k = lat[LSB + SEL_W];
    assign out_en[k] = en_k;
    assign out_sel[k*SEL_W +: SEL_W] = en_k ? lat[LSB +: SEL_W] : '0;
  end

  assign clamp_en       = lat[FRAME-1];
  assign test_mode_flag = |lat[PAD_W-1:0];
endmodule

// File: rtl/xpt_cfg_port.sv
module xpt_cfg_port
  import xpt_cfg_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_OUT = 16,
  localparam int SEL_W   = $clog2(N_IN),
  localparam int FIELD_W = SEL_W + 1,
  localparam int PAD_W   = N_OUT * FIELD_W,
  localparam int FRAME   = 1 + N_OUT * FIELD_W + PAD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_din,
  input  logic                   ser_cs_n,
  input  logic                   upd_n,
  output logic                   ser_dout,
  output logic [N_OUT-1:0]       out_en,
  output logic [N_OUT*SEL_W-1:0] out_sel,
  output logic                   clamp_en,
  output logic                   test_mode_flag
);
  ser_pins_t pins_raw, pins_s;
  logic [FRAME-1:0] sr, lat;

  assign pins_raw = '{sclk: ser_clk, sdin: ser_din, cs_n: ser_cs_n, upd_n: upd_n};

  xpt_sync #(.W($bits(ser_pins_t)), .RST_VAL(SER_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  xpt_cfg_shift #(.FRAME(FRAME)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s.sclk), .sdin_s(pins_s.sdin),
    .cs_n_s(pins_s.cs_n), .sr(sr), .sdout(ser_dout)
  );

  xpt_cfg_latch #(.FRAME(FRAME)) u_latch (
    .clk(clk), .rst_n(rst_n), .sr(sr), .upd_n_s(pins_s.upd_n),
    .cs_n_s(pins_s.cs_n), .lat(lat)
  );

  xpt_cfg_decode #(.N_OUT(N_OUT), .SEL_W(SEL_W), .PAD_W(PAD_W)) u_dec (
    .lat(lat), .out_en(out_en), .out_sel(out_sel),
    .clamp_en(clamp_en), .test_mode_flag(test_mode_flag)
  );

  AST_FLAG_RISES_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode_flag) |-> $past(!pins_s.upd_n && !pins_s.cs_n)); // R10

  AST_CLAMP_MOVES_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clamp_en) |-> $past(!pins_s.upd_n)); // R9
endmodule

// File: tb/tb_xpt_cfg_port.sv
module tb_xpt_cfg_port;
  localparam int NO = 16, SW = 5, FR = 193, PW = 96, HALF = 6;

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_din = 0, ser_cs_n = 1, upd_n = 1;
  logic ser_dout, clamp_en, test_mode_flag;
  logic [NO-1:0] out_en;
  logic [NO*SW-1:0] out_sel;

  xpt_cfg_port dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_cs_n(ser_cs_n), .upd_n(upd_n), .ser_dout(ser_dout), .out_en(out_en),
    .out_sel(out_sel), .clamp_en(clamp_en), .test_mode_flag(test_mode_flag));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [FR-1:0] sr_m = '0, lat_m = '0;

  task automatic chk(input bit ok, input string tag, input logic [199:0] act, input logic [199:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FR-1:0] build(input logic clamp, input logic [NO-1:0] en,
                                           input logic [NO*SW-1:0] sel, input logic [PW-1:0] pad);
    logic [FR-1:0] v;
    v[FR-1] = clamp;
    for (int k = 0; k < NO; k++) v[PW + 6*k +: 6] = {en[k], sel[k*SW +: SW]};
    v[PW-1:0] = pad;
    return v;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 0;
    repeat (HALF) @(negedge clk);
    ser_clk = 1;
    repeat (HALF) @(negedge clk);
    if (!ser_cs_n) sr_m = {sr_m[FR-2:0], b};
  endtask

  task automatic send_frame(input logic [FR-1:0] v);
    for (int i = FR - 1; i >= 0; i--) send_bit(v[i]);
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_update();
    @(negedge clk); upd_n = 0;
    repeat (8) @(negedge clk);
    upd_n = 1;
    repeat (8) @(negedge clk);
    if (!ser_cs_n) lat_m = sr_m;
  endtask

  // Expected outputs from latched word, using field positions of R3
  task automatic check_lat(input string tag);
    logic [NO-1:0] e_en; logic [NO*SW-1:0] e_sel;
    for (int k = 0; k < NO; k++) begin
      e_en[k] = lat_m[PW + 6*k + 5];
      e_sel[k*SW +: SW] = e_en[k] ? lat_m[PW + 6*k +: SW] : '0;
    end
    chk(out_en == e_en, {tag, " out_en"}, out_en, e_en);
    chk(out_sel == e_sel, {tag, " out_sel R6"}, out_sel, e_sel);
    chk(clamp_en == lat_m[FR-1], {tag, " clamp R9"}, clamp_en, lat_m[FR-1]);
    chk(test_mode_flag == (|lat_m[PW-1:0]), {tag, " flag R10"}, test_mode_flag, |lat_m[PW-1:0]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [FR-1:0] fa, fb;
    logic [NO-1:0] en; logic [NO*SW-1:0] sel;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(out_en == 0 && out_sel == 0 && !clamp_en && !test_mode_flag && !ser_dout,
        "R8 reset state", {out_en, out_sel, clamp_en, test_mode_flag, ser_dout}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    ser_cs_n = 0;

    // R1 R3 R6 R9: sweep every source index over every destination
    for (int s = 0; s < 32; s++) begin
      for (int k = 0; k < NO; k++) begin
        en[k] = ((k + s) % 3) != 0;
        sel[k*SW +: SW] = SW'((k + s) % 32);
      end
      fa = build(s[0], en, sel, '0);
      send_frame(fa);
      if (s == 0) chk(out_en == 0 && out_sel == 0, "R5 hold before update", {out_en, out_sel}, 0);
      pulse_update();
      chk(out_en == en, "R3 enables", out_en, en);
      for (int k = 0; k < NO; k++)
        chk(out_sel[k*SW +: SW] == (en[k] ? sel[k*SW +: SW] : 5'd0), "R6 R3 index field",
            out_sel[k*SW +: SW], en[k] ? sel[k*SW +: SW] : 5'd0);
      chk(clamp_en == s[0], "R9 clamp", clamp_en, s[0]);
      chk(!test_mode_flag, "R10 zero padding", test_mode_flag, 0);
    end

    // R7: chained output tracks the bit shifted 192 edges earlier
    fb = build(1'b1, 16'hA5C3, {16{5'b10110}}, {48{2'b01}});
    for (int i = FR - 1; i >= 0; i--) begin
      send_bit(fb[i]);
      chk(ser_dout == sr_m[FR-1], "R7 dout", ser_dout, sr_m[FR-1]);
    end
    repeat (8) @(negedge clk);
    chk(ser_dout == fb[FR-1], "R7 first bit out after full word", ser_dout, fb[FR-1]);

    // R5: word shifted with update high leaves outputs alone
    check_lat("R5 hold after shifting");
    // R2: deselected update and clocks do nothing
    ser_cs_n = 1;
    pulse_update();
    check_lat("R2 update while deselected");
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    ser_cs_n = 0;
    repeat (4) @(negedge clk);
    pulse_update();
    chk(lat_m == fb, "R2 register unchanged while deselected", lat_m, fb);
    check_lat("R2 R10 load after reselect");
    chk(test_mode_flag == 1'b1, "R10 nonzero padding", test_mode_flag, 1);

    // R4: transparent while update low
    @(negedge clk); upd_n = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      send_bit(i[0]);
      repeat (4) @(negedge clk);
      lat_m = sr_m;
      check_lat("R4 transparent");
    end
    upd_n = 1;
    repeat (8) @(negedge clk);

    // R8: asynchronous reset mid-run
    @(negedge clk); #1 rst_n = 0;
    #0.5;
    chk(out_en == 0 && !clamp_en && !test_mode_flag && !ser_dout, "R8 async clear",
        {out_en, clamp_en, test_mode_flag, ser_dout}, 0);
    sr_m = '0; lat_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    pulse_update();
    check_lat("R8 register cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule